// File: doc/BRIEF.md
# Programmable Waveform Timer Output

This block is a down-counting timer whose single output pin takes a level chosen by software each time the count passes through zero. Software writes a reload value, a prescaler select and a control byte. The control byte carries the mode field, a run bit and a level latch. While the block runs, the counter counts the prescaled clock down to zero, then reloads. At that same edge the level latch is copied to the pin and a sticky interrupt request is raised.

Software can rewrite the level latch and the reload latch after each underflow. The pin then steps through any chosen sequence of levels, and each level lasts as long as software chooses. The block does not toggle the pin on its own. A two-state controller governs counting. In `ST_STOP` the counter and pin hold. The transition *start* (STOP to RUN, taken when the run request appears) loads the counter from the reload latch. In `ST_RUN` the counter counts prescaler ticks. The transition *halt* (RUN to STOP) is taken when the run request drops.

Top module: `pwg_timer`

## Requirements
- R1: After reset `wave_out`, `wave_oe` and `irq` are all 0.
- R2: The block is active only when control bits [2:0] equal 3'b100 and control bit 7 is 0. `wave_oe` is 1 exactly when the block is active. When it is inactive there is no counting and no interrupt.
- R3: Prescaler select s (register 3, bits [3:0]) gives a tick every 2^(s+1) clocks for s = 0..9. Any value from 10 to 15 gives a tick every 1024 clocks.
- R4: The block starts when control bit 3 (run) is set while it is active. The counter is then loaded from the reload latch, and the first underflow comes N*(R+1)+1 clocks after the edge that wrote the control byte.
- R5: While the block runs with reload R and division N, successive underflows are N*(R+1) clocks apart.
- R6: At each underflow `wave_out` takes the value that control bit 4 held before that edge. A write to the level bit that lands on the underflow edge first shows at the next underflow.
- R7: A write to address 0 stages the low byte, and a write to address 1 supplies the high byte and commits the full reload latch. The counter takes a new latch value at the next underflow, so it sets the length of the interval that follows.
- R8: `irq` is set by an underflow and stays set until a write to address 4 with bit 0 equal to 0 clears it. When an underflow and a clear fall on the same edge, `irq` stays set.
- R9: When the run bit is cleared, no further underflow or interrupt occurs and `wave_out` holds its last level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 reload low, 1 reload high, 2 control, 3 prescaler, 4 status |
| wr_data | input | 8 | Register write data |
| wave_out | output | 1 | Waveform pin level |
| wave_oe | output | 1 | Pin drive enable, high while the block is active |
| irq | output | 1 | Sticky underflow interrupt request |

## Verification
An underflow and a software register write can land on the same clock edge. Two such cases matter: an interrupt clear, and a rewrite of the level latch. The bench predicts the underflow edge from the reload and division values it programmed. It then times the write so that it lands on exactly that edge. The bench judges the clear case by `irq` staying set. It judges the level case by the pin taking the old latch value at that underflow and the new value at the following one.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RLD_LO = 3'd0,
        REG_RLD_HI = 3'd1,
        REG_CTRL   = 3'd2,
        REG_PRESC  = 3'd3,
        REG_STAT   = 3'd4
    } reg_addr_e;

    localparam logic [2:0] WAVE_MODE = 3'b100;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic       evsel;
        logic [1:0] spare;
        logic       level;
        logic       run;
        logic [2:0] mode;
    } ctrl_t;

endpackage

// File: rtl/pwg_regs.sv
module pwg_regs
    import pwg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic [CNT_W-1:0]     reload,
    output ctrl_t                ctrl,
    output logic [SEL_W-1:0]     presc_sel,
    output logic                 irq_clr
);

    localparam int HI_W = CNT_W - 8;

    logic [7:0] lo_stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_stage_q <= '0;
            reload     <= '0;
            ctrl       <= '0;
            presc_sel  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_RLD_LO: lo_stage_q <= wr_data;
                REG_RLD_HI: reload     <= {wr_data[HI_W-1:0], lo_stage_q};
                REG_CTRL:   ctrl       <= ctrl_t'(wr_data);
                REG_PRESC:  presc_sel  <= wr_data[SEL_W-1:0];
                default:    ;
            endcase
        end
    end

    assign irq_clr = wr_en && (wr_addr == REG_STAT) && !wr_data[0];

endmodule

// File: rtl/pwg_prescaler.sv
module pwg_prescaler #(
    parameter int STEPS = 10,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(STEPS - 1);

    logic [STEPS-1:0] cnt_q;
    logic [STEPS-1:0] mask;
    logic [SEL_W-1:0] sel_c;

    assign sel_c = (sel > SEL_MAX) ? SEL_MAX : sel;

    for (genvar g = 0; g < STEPS; g++) begin : g_mask
        assign mask[g] = (sel_c >= SEL_W'(g));
    end

    assign tick = en && ((cnt_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwg_core.sv
module pwg_core
    import pwg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             level,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             irq_clr,
    output logic             running,
    output logic             uf,
    output logic             wave,
    output logic             irq
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    assign start   = (state_q == ST_STOP) && run_req;
    assign running = (state_q == ST_RUN) && run_req;
    assign uf      = running && tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wave  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (start)
                cnt_q <= reload;
            else if (running && tick)
                cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
            if (uf)
                wave <= level;
            if (uf)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

endmodule

// File: rtl/pwg_timer.sv
module pwg_timer
    import pwg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_STEPS = 10,
    parameter int SEL_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wave_out,
    output logic              wave_oe,
    output logic              irq
);

    logic [CNT_W-1:0] reload;
    ctrl_t            ctrl;
    logic [SEL_W-1:0] presc_sel;
    logic             irq_clr;
    logic             run_req;
    logic             running;
    logic             tick;
    logic             uf;

    pwg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reload    (reload),
        .ctrl      (ctrl),
        .presc_sel (presc_sel),
        .irq_clr   (irq_clr)
    );

    assign wave_oe = (ctrl.mode == WAVE_MODE) && !ctrl.evsel;
    assign run_req = wave_oe && ctrl.run;

    pwg_prescaler #(.STEPS(DIV_STEPS), .SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .sel   (presc_sel),
        .tick  (tick)
    );

    pwg_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .level   (ctrl.level),
        .reload  (reload),
        .tick    (tick),
        .irq_clr (irq_clr),
        .running (running),
        .uf      (uf),
        .wave    (wave_out),
        .irq     (irq)
    );

endmodule

// File: rtl/pwg_timer_chk.sv
module pwg_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       wave_out,
    input logic       wave_oe,
    input logic       irq,
    input logic       uf,
    input logic       running
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == 3'd4) && !wr_data[0];

    a_r6_wave_moves_only_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_out) |-> irq);

    a_r8_uf_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> irq);

    a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !uf) |=> !irq);

    a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_wr));

    a_r2_no_uf_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_oe |-> !uf);

    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> $stable(wave_out));

endmodule

bind pwg_timer pwg_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wave_out (wave_out),
    .wave_oe  (wave_oe),
    .irq      (irq),
    .uf       (uf),
    .running  (running)
);

// File: tb/test_pwg_timer.sv
`timescale 1ns/1ps
module test_pwg_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wave_out, wave_oe, irq;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int wcyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwg_timer i_pwg_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wave_out(wave_out), .wave_oe(wave_oe), .irq(irq)
    );

    function automatic int period(int r, int s);
        int n;
        n = (s > 9) ? 1024 : (1 << (s + 1));
        return (r + 1) * n;
    endfunction

    function automatic logic [7:0] ctl(bit run, bit lvl);
        return 8'h04 | (run ? 8'h08 : 8'h00) | (lvl ? 8'h10 : 8'h00);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_now(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 8'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        wcyc  = cyc;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic wait_uf(output int c);
        int k;
        k = 0;
        c = -1;
        while (k < 5000) begin
            @(negedge clk);
            if (irq) begin
                c = cyc;
                break;
            end
            k++;
        end
        chk(c >= 0, "R8 underflow seen", c, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c, prev, gov, rld, sel, target, w, bad;
        bit lvl, nl;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wave_out == 0, "R1 wave", wave_out, 0);
        chk(wave_oe == 0, "R1 oe", wave_oe, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rst_n = 1'b1;

        // R2: wrong mode field, then event switch set
        wr(0, 3); wr(1, 0); wr(3, 0);
        wr(2, 8'h0B);
        repeat (60) @(negedge clk);
        chk(wave_oe == 0, "R2 oe bad mode", wave_oe, 0);
        chk(irq == 0, "R2 irq bad mode", irq, 0);
        wr(2, 8'h8C);
        repeat (60) @(negedge clk);
        chk(wave_oe == 0, "R2 oe evsel", wave_oe, 0);
        chk(irq == 0, "R2 irq evsel", irq, 0);
        wr(2, ctl(0, 0));
        chk(wave_oe == 1, "R2 oe active", wave_oe, 1);

        // R4 directed start, N=2, R=4
        wr(0, 4); wr(1, 0); wr(3, 0);
        wr(2, ctl(1, 1));
        w = wcyc;
        wait_uf(c);
        chk(c == w + 1 + period(4, 0), "R4 first underflow", c - w, 1 + period(4, 0));
        chk(wave_out == 1, "R6 level copied", wave_out, 1);
        wr(4, 0);
        chk(irq == 0, "R8 clear", irq, 0);

        // random division, restart
        sel = $urandom % 4;
        rld = 3 + $urandom % 20;
        lvl = 0;
        wr(2, ctl(0, 1));
        wr(3, sel); wr(0, rld); wr(1, 0);
        wr(2, ctl(1, lvl));
        w = wcyc;
        wait_uf(c);
        chk(c == w + 1 + period(rld, sel), "R3/R4 restart", c - w, 1 + period(rld, sel));
        chk(wave_out == lvl, "R6 restart level", wave_out, lvl);
        prev = c; gov = rld;

        // R5/R7 random segment sequence
        for (int i = 0; i < 20; i++) begin
            wr(4, 0);
            nl = 1'($urandom % 2);
            rld = 3 + $urandom % 38;
            wr(2, ctl(1, nl));
            wr(0, rld & 8'hFF); wr(1, rld >> 8);
            wait_uf(c);
            chk(c - prev == period(gov, sel), "R5/R7 interval", c - prev, period(gov, sel));
            chk(wave_out == nl, "R6 segment level", wave_out, nl);
            lvl = nl; gov = rld; prev = c;
        end

        // R8 collision: clear lands on underflow edge
        wr(4, 0);
        target = prev + period(gov, sel);
        while (cyc < target - 1) @(negedge clk);
        wr_now(4, 0);
        chk(cyc == target, "R5 collision edge", cyc, target);
        chk(irq == 1, "R8 set wins over clear", irq, 1);
        chk(wave_out == lvl, "R6 level at collision", wave_out, lvl);
        prev = target;
        wr(4, 0);
        chk(irq == 0, "R8 clear after", irq, 0);

        // R6 collision: level write lands on underflow edge
        target = prev + period(gov, sel);
        nl = ~lvl;
        while (cyc < target - 1) @(negedge clk);
        wr_now(2, ctl(1, nl));
        chk(wave_out == lvl, "R6 old level on edge write", wave_out, lvl);
        chk(irq == 1, "R8 set on collision", irq, 1);
        prev = target;
        wr(4, 0);
        wait_uf(c);
        chk(c - prev == period(gov, sel), "R5 after collision", c - prev, period(gov, sel));
        chk(wave_out == nl, "R6 new level next", wave_out, nl);
        lvl = nl;

        // R9 stop holds
        wr(2, ctl(0, ~lvl));
        wr(4, 0);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq || wave_out != lvl) bad++;
        end
        chk(bad == 0, "R9 hold while stopped", bad, 0);

        // R3 clamp: select 12 acts as 1024, R=0
        wr(3, 12); wr(0, 0); wr(1, 0);
        wr(2, ctl(1, ~lvl));
        w = wcyc;
        wait_uf(c);
        chk(c == w + 1 + 1024, "R3 clamp 1024", c - w, 1025);
        chk(wave_out == !lvl, "R6 level after restart", wave_out, !lvl);

        // R4 boundary: N=2, R=0
        wr(2, ctl(0, 0));
        wr(4, 0);
        wr(3, 0);
        wr(2, ctl(1, 0));
        w = wcyc;
        wait_uf(c);
        chk(c == w + 1 + 2, "R4 minimum period", c - w, 3);
        chk(wave_out == 0, "R6 low level", wave_out, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule